// File: doc/BRIEF.md
# Holdover History Capture Controller

This block keeps the frequency word that a clock synthesizer falls back on when it enters holdover. It watches the loop's lock indication and two loss indications, signal loss and lock loss. It runs a qualification timer that advances on a slow, programmable tick. The tick is meant to come from a prescaler. Once the loop has stayed clean for the whole qualification window, the block copies the long-term averaged frequency word into a device history register and keeps refreshing it every cycle. The first sign of trouble freezes that register. The timer then starts over from zero.

A host can write its own history word into a user register and read it back. A select input picks which of the two words drives the holdover output. The block reports whether the device register is currently tracking. It also reports whether the selected source holds a valid word. The averaging filter and the loop itself sit outside this block.

Top module: `holdover_hist_ctrl`

## Requirements
- R1: While reset is asserted, and for the two synchronizer cycles after it is released, device_hist_o and user_hist_o are zero, and tracking_o and hist_avail_o are low.
- R2: The link is clean in a cycle when ref_locked_i=1, sig_lost_i=0 and lock_lost_i=0. tracking_o rises at the clock edge that closes the QUAL_TICKS-th cycle that is both clean and carries qual_tick_i=1. Clean cycles without a tick do not advance the count.
- R3: A cycle that is not clean clears the qualification count. After it, a full QUAL_TICKS of fresh clean ticks is needed before tracking_o rises again.
- R4: At each clock edge closing a clean cycle in which tracking_o was high, device_hist_o takes the value long_avg_i had in that cycle.
- R5: At each clock edge closing a cycle that is not clean, tracking_o goes low and device_hist_o keeps its previous value.
- R6: If a loss falls in the same cycle as the tick that would complete qualification, the loss wins: tracking_o stays low and the count restarts from zero.
- R7: When user_wr_i=1 at a clock edge, user_hist_o shows user_wdata_i from that edge on. Otherwise user_hist_o holds its value.
- R8: holdover_val_o equals user_hist_o when use_user_i=1 and device_hist_o when use_user_i=0. The selection is combinational.
- R9: hist_avail_o shows the valid flag of the selected source. The user flag is set by the first write. The device flag is set by the first capture from the long-term average.
- R10: Once set, the device and user valid flags stay set through any loss and are cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_locked_i | input | 1 | Loop is locked to the selected reference |
| sig_lost_i | input | 1 | Signal loss on the selected reference |
| lock_lost_i | input | 1 | Loss of lock indication |
| qual_tick_i | input | 1 | One-cycle pulse advancing the qualification timer |
| long_avg_i | input | W | Long-term averaged frequency word |
| use_user_i | input | 1 | 1 selects the user history, 0 the device history |
| user_wr_i | input | 1 | Write strobe for the user history |
| user_wdata_i | input | W | Data for the user history |
| device_hist_o | output | W | Device history word |
| user_hist_o | output | W | User history word, readback |
| holdover_val_o | output | W | History word selected for holdover |
| tracking_o | output | 1 | Device history is following the average |
| hist_avail_o | output | 1 | Selected source holds a valid word |

## Verification
The delicate coincidence is a loss arriving in the same cycle as the tick that would finish qualification. The timer must restart and must not promote. A sweep slides each of the three loss kinds across every tick position of a short window, with and without idle gaps between ticks. The run therefore hits that cycle exactly, and also hits a loss landing during active tracking. Some sweep points also put a user write, or a switch of the select input, in that same cycle. After every cycle, each output is compared against a model in the bench written from the requirements.

// File: rtl/holdover_pkg.sv
package holdover_pkg;
  typedef enum logic {
    SRC_DEVICE = 1'b0,
    SRC_USER   = 1'b1
  } hist_src_e;
endpackage

// File: rtl/hoh_qual_timer.sv
module hoh_qual_timer #(
  parameter int unsigned QUAL_TICKS = 900
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clean_i,
  output logic qualified_o
);
  localparam int unsigned CNT_W = (QUAL_TICKS < 2) ? 1 : $clog2(QUAL_TICKS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             qual_q, qual_d;

  always_comb begin
    cnt_d  = cnt_q;
    qual_d = qual_q;
    if (!clean_i) begin
      cnt_d  = '0;
      qual_d = 1'b0;
    end else if (tick_i && !qual_q) begin
      if (cnt_q == LAST) begin
        qual_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      qual_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      qual_q <= qual_d;
    end
  end

  assign qualified_o = qual_q;
endmodule

// File: rtl/hoh_hist_reg.sv
module hoh_hist_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] hist_o,
  output logic         valid_o
);
  logic [W-1:0] hist_q, hist_d;
  logic         vld_q, vld_d;

  always_comb begin
    hist_d = hist_q;
    vld_d  = vld_q;
    if (load_i) begin
      hist_d = data_i;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      vld_q  <= vld_d;
    end
  end

  assign hist_o  = hist_q;
  assign valid_o = vld_q;
endmodule

// File: rtl/hoh_src_mux.sv
module hoh_src_mux
  import holdover_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  hist_src_e    src_i,
  input  logic [W-1:0] dev_i,
  input  logic         dev_vld_i,
  input  logic [W-1:0] usr_i,
  input  logic         usr_vld_i,
  output logic [W-1:0] val_o,
  output logic         avail_o
);
  always_comb begin
    unique case (src_i)
      SRC_USER: begin
        val_o   = usr_i;
        avail_o = usr_vld_i;
      end
      default: begin
        val_o   = dev_i;
        avail_o = dev_vld_i;
      end
    endcase
  end
endmodule

// File: rtl/holdover_hist_ctrl.sv
module holdover_hist_ctrl
  import holdover_pkg::*;
#(
  parameter int unsigned W          = 32,
  parameter int unsigned QUAL_TICKS = 900
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ref_locked_i,
  input  logic         sig_lost_i,
  input  logic         lock_lost_i,
  input  logic         qual_tick_i,
  input  logic [W-1:0] long_avg_i,
  input  logic         use_user_i,
  input  logic         user_wr_i,
  input  logic [W-1:0] user_wdata_i,
  output logic [W-1:0] device_hist_o,
  output logic [W-1:0] user_hist_o,
  output logic [W-1:0] holdover_val_o,
  output logic         tracking_o,
  output logic         hist_avail_o
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[SYNC_STAGES-1];

  logic link_clean;
  logic qualified;
  logic dev_load;
  logic dev_vld, usr_vld;

  assign link_clean = ref_locked_i & ~sig_lost_i & ~lock_lost_i;
  assign dev_load   = qualified & link_clean;

  hoh_qual_timer #(.QUAL_TICKS(QUAL_TICKS)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .tick_i     (qual_tick_i),
    .clean_i    (link_clean),
    .qualified_o(qualified)
  );

  hoh_hist_reg #(.W(W)) u_dev_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .load_i (dev_load),
    .data_i (long_avg_i),
    .hist_o (device_hist_o),
    .valid_o(dev_vld)
  );

  hoh_hist_reg #(.W(W)) u_usr_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .load_i (user_wr_i),
    .data_i (user_wdata_i),
    .hist_o (user_hist_o),
    .valid_o(usr_vld)
  );

  hoh_src_mux #(.W(W)) u_mux (
    .src_i    (hist_src_e'(use_user_i)),
    .dev_i    (device_hist_o),
    .dev_vld_i(dev_vld),
    .usr_i    (user_hist_o),
    .usr_vld_i(usr_vld),
    .val_o    (holdover_val_o),
    .avail_o  (hist_avail_o)
  );

  assign tracking_o = qualified;
endmodule

// File: rtl/holdover_hist_chk.sv
module holdover_hist_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ref_locked_i,
  input logic         sig_lost_i,
  input logic         lock_lost_i,
  input logic         qual_tick_i,
  input logic [W-1:0] long_avg_i,
  input logic         use_user_i,
  input logic         user_wr_i,
  input logic [W-1:0] user_wdata_i,
  input logic [W-1:0] device_hist_o,
  input logic [W-1:0] user_hist_o,
  input logic [W-1:0] holdover_val_o,
  input logic         tracking_o,
  input logic         hist_avail_o
);
  logic clean;
  assign clean = ref_locked_i & ~sig_lost_i & ~lock_lost_i;

  // R5
  trk_drop_on_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clean |=> !tracking_o);

  // R5
  dev_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clean |=> $stable(device_hist_o));

  // R4
  dev_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tracking_o && clean) |=> (device_hist_o == $past(long_avg_i)));

  // R2
  trk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tracking_o) |-> $past(clean && qual_tick_i));

  // R7
  usr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_wr_i |=> (user_hist_o == $past(user_wdata_i)));

  // R7
  usr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !user_wr_i |=> $stable(user_hist_o));

  // R8
  sel_user_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_user_i |-> (holdover_val_o == user_hist_o));

  // R8
  sel_dev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !use_user_i |-> (holdover_val_o == device_hist_o));

  // R10
  avail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!use_user_i && $past(!use_user_i) && $past(hist_avail_o)) |-> hist_avail_o);
endmodule

bind holdover_hist_ctrl holdover_hist_chk #(.W(W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ref_locked_i  (ref_locked_i),
  .sig_lost_i    (sig_lost_i),
  .lock_lost_i   (lock_lost_i),
  .qual_tick_i   (qual_tick_i),
  .long_avg_i    (long_avg_i),
  .use_user_i    (use_user_i),
  .user_wr_i     (user_wr_i),
  .user_wdata_i  (user_wdata_i),
  .device_hist_o (device_hist_o),
  .user_hist_o   (user_hist_o),
  .holdover_val_o(holdover_val_o),
  .tracking_o    (tracking_o),
  .hist_avail_o  (hist_avail_o)
);

// File: tb/holdover_hist_ctrl_tb.sv
`timescale 1ns/1ps
module holdover_hist_ctrl_tb;
  localparam int W = 8;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk = 1'b0, sl = 1'b0, ll = 1'b0, tk = 1'b0;
  logic [W-1:0] avg = '0;
  logic sel = 1'b0, wr = 1'b0;
  logic [W-1:0] wd = '0;
  logic [W-1:0] dev_o, usr_o, val_o;
  logic trk_o, avail_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int m_cnt = 0;
  bit m_trk = 1'b0, m_devv = 1'b0, m_usrv = 1'b0;
  logic [W-1:0] m_dev = '0, m_usr = '0;
  int cyc_no = 0;

  always #10 clk = ~clk;

  holdover_hist_ctrl #(.W(W), .QUAL_TICKS(Q)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_locked_i(lk), .sig_lost_i(sl),
    .lock_lost_i(ll), .qual_tick_i(tk), .long_avg_i(avg), .use_user_i(sel),
    .user_wr_i(wr), .user_wdata_i(wd), .device_hist_o(dev_o),
    .user_hist_o(usr_o), .holdover_val_o(val_o), .tracking_o(trk_o),
    .hist_avail_o(avail_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d cycle=%0d", tag, act, exp, cyc_no);
    end
  endtask

  task automatic check_outs();
    logic [W-1:0] ev;
    bit ea;
    ev = sel ? m_usr : m_dev;
    ea = sel ? m_usrv : m_devv;
    chk(trk_o == m_trk, "R2/R3/R6 tracking_o", int'(trk_o), int'(m_trk));
    chk(dev_o == m_dev, "R4/R5 device_hist_o", int'(dev_o), int'(m_dev));
    chk(usr_o == m_usr, "R7 user_hist_o", int'(usr_o), int'(m_usr));
    chk(val_o == ev, "R8 holdover_val_o", int'(val_o), int'(ev));
    chk(avail_o == ea, "R9/R10 hist_avail_o", int'(avail_o), int'(ea));
  endtask

  // one clock: model advances from the inputs held in this cycle
  task automatic step();
    bit clean;
    clean = lk && !sl && !ll;
    if (wr) begin m_usr = wd; m_usrv = 1'b1; end
    if (!clean) begin
      m_cnt = 0; m_trk = 1'b0;
    end else begin
      if (m_trk) begin m_dev = avg; m_devv = 1'b1; end
      else if (tk) begin
        if (m_cnt == Q - 1) begin m_trk = 1'b1; m_cnt = 0; end
        else m_cnt++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    cyc_no++;
    check_outs();
  endtask

  task automatic set_idle();
    lk = 1'b0; sl = 1'b0; ll = 1'b0; tk = 1'b0; wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    set_idle();
    sel = 1'b0;
    m_cnt = 0; m_trk = 1'b0; m_devv = 1'b0; m_usrv = 1'b0;
    m_dev = '0; m_usr = '0;
    @(negedge clk);
    // R1: reset state
    chk(dev_o == '0 && usr_o == '0 && !trk_o && !avail_o, "R1 reset outputs",
        int'({trk_o, avail_o}), 0);
    rst_n = 1'b1;
    step(); step(); step();
  endtask

  initial begin
    do_reset();
    for (int kind = 0; kind < 3; kind++) begin
      for (int p = 0; p <= Q + 2; p++) begin
        for (int gap = 0; gap < 2; gap++) begin
          set_idle();
          lk = 1'b1;
          sel = ((p + kind) % 2) == 1;
          for (int i = 0; i < Q + 3; i++) begin
            tk = 1'b1;
            avg = W'(cyc_no * 37 + 5);
            if (i == p) begin
              // R3/R6: loss on a tick cycle; p==Q-1 hits the final tick
              if (kind == 0) lk = 1'b0;
              if (kind == 1) sl = 1'b1;
              if (kind == 2) ll = 1'b1;
              wr = 1'b1;
              wd = W'(p * 11 + kind * 3 + gap + 1);
              sel = ~sel;
            end
            step();
            lk = 1'b1; sl = 1'b0; ll = 1'b0; wr = 1'b0;
            for (int g = 0; g < gap; g++) begin
              tk = 1'b0;
              avg = W'(cyc_no * 53 + 9);
              step();
            end
          end
          tk = 1'b0;
          avg = W'(cyc_no * 13 + 2);
          step();
          // R5/R10: drop the link and confirm freeze
          lk = 1'b0;
          avg = ~avg;
          step();
          step();
        end
      end
    end
    // R8: combinational select, no clock edge between
    @(negedge clk);
    sel = 1'b1; #1;
    chk(val_o == m_usr, "R8 select user comb", int'(val_o), int'(m_usr));
    sel = 1'b0; #1;
    chk(val_o == m_dev, "R8 select device comb", int'(val_o), int'(m_dev));
    // R1/R10: valid flags cleared only by reset
    do_reset();
    chk(!avail_o, "R10 valid cleared by reset", int'(avail_o), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule